// File: doc/BRIEF.md
# Packet Timestamp Capture with Receive Slot Pool

This block samples a free-running nanosecond time value at the moment a precision-time event frame leaves or arrives at the port. Transmit events use a single capture register. Receive events draw from a pool of four capture slots. For each receive event the block reports the slot it used, so that the receive path can attach that index to the frame. Software later fetches the matching capture using that index.

Each capture is 64 bits wide and is read as two 32-bit words. The low word is read first. Reading the high word is the release: it frees the receive slot, or clears the transmit latch. While every receive slot is held, further receive events are reported as not stamped and leave the stored captures untouched. Receive capture is qualified by a message-version selection and by a gate for UDP-carried frames. Transmit capture is always active. Its completion drives an interrupt that a control bit can mask.

Top module: `ptp_ts_capture`

## Requirements
- R1: After reset all latches are clear: the status word reads 0, `tx_irq` is 0, and `rx_stamped` and `rx_nostamp` are 0.
- R2: A qualified receive event takes the lowest-numbered free slot. One cycle later `rx_stamped` pulses with `rx_slot` set to that index. The slot holds the `time_ns` value present at the event's clock edge.
- R3: Register address 0 reads the status word. Bit i (i = 0..3) is the latch of receive slot i and bit 4 is the transmit latch. Reading it changes nothing.
- R4: Reads return on `rd_data` one cycle after `rd_en`. The transmit capture sits at address 1 (bits 31:0) and address 2 (bits 63:32). Receive slot i sits at address 3+2i (low word) and 4+2i (high word).
- R5: Reading a high word clears the matching latch (receive slot or transmit). Reading a low word clears nothing.
- R6: A qualified receive event that finds all four slots held produces a one-cycle `rx_nostamp` pulse instead of `rx_stamped`.
- R7: Receive events are qualified as follows. `cfg_rx_mode` 0 or 3 accepts none, 1 accepts frames with `rx_ver`=1, and 2 accepts frames with `rx_ver`=2. A frame with `rx_udp`=1 is accepted only while `cfg_udp_en`=1. An unqualified event raises neither `rx_stamped` nor `rx_nostamp` and captures nothing.
- R8: A transmit event latches `time_ns` when the transmit latch is clear. While the latch is set, further transmit events leave the first capture in place.
- R9: `tx_irq` is high exactly while the transmit latch is set and `cfg_tx_irq_en` is 1.
- R10: When a high-word read and a new capture hit the same slot in one cycle, the clear is applied first. The new capture then latches, and the read returns the old value.
- R11: A held receive slot keeps its stored value until it is released, whatever events arrive meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_ns | input | 64 | Current nanosecond time |
| tx_evt | input | 1 | Transmit event strobe |
| rx_evt | input | 1 | Receive event strobe |
| rx_ver | input | 2 | Message version of the received frame |
| rx_udp | input | 1 | Received frame is carried over UDP |
| cfg_rx_mode | input | 2 | Receive filter: 0 off, 1 version 1, 2 version 2, 3 off |
| cfg_udp_en | input | 1 | Accept UDP-carried frames |
| cfg_tx_irq_en | input | 1 | Transmit interrupt enable |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Read data, one cycle after rd_en |
| rx_stamped | output | 1 | Receive event was stamped |
| rx_nostamp | output | 1 | Qualified receive event found no free slot |
| rx_slot | output | 2 | Slot index used by the stamped event |
| tx_irq | output | 1 | Transmit capture interrupt |

## Verification
The bench fills all four slots and then sends one more event. A design without the full check would overwrite a held capture, or report a stamp it never stored. Releasing a middle slot and sending a new event shows whether allocation really picks the lowest free index rather than rotating. A high-word read of slot 0 issued in the same cycle as a new receive event tells whether the clear is ordered before the capture. A wrong order leaves the slot free, with status bit 0 low, even though a stamp was reported. Low-word and status reads are checked to release nothing. A second transmit event is checked not to replace the first capture.

// File: rtl/ptp_ts_capture.sv
module ptp_ts_capture #(
  parameter int TS_W = 64,
  parameter int DW   = 32,
  parameter int N_RX = 4,
  parameter int AW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TS_W-1:0] time_ns,
  input  logic            tx_evt,
  input  logic            rx_evt,
  input  logic [1:0]      rx_ver,
  input  logic            rx_udp,
  input  logic [1:0]      cfg_rx_mode,
  input  logic            cfg_udp_en,
  input  logic            cfg_tx_irq_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   rd_addr,
  output logic [DW-1:0]   rd_data,
  output logic            rx_stamped,
  output logic            rx_nostamp,
  output logic [$clog2(N_RX)-1:0] rx_slot,
  output logic            tx_irq
);
  localparam int SW    = $clog2(N_RX);
  localparam int A_TXL = 1;
  localparam int A_TXH = 2;
  localparam int A_RX0 = 3;

  logic [N_RX-1:0] rx_lat, rx_clr, avail, grant;
  logic [TS_W-1:0] rx_cap [N_RX];
  logic [TS_W-1:0] tx_cap;
  logic            tx_lat, tx_clr, rx_hit, found;
  logic [SW-1:0]   gidx;
  logic [DW-1:0]   rd_mux;

  assign rx_hit = rx_evt && (cfg_rx_mode == 2'd1 || cfg_rx_mode == 2'd2) &&
                  rx_ver == cfg_rx_mode && (!rx_udp || cfg_udp_en);
  assign tx_clr = rd_en && rd_addr == AW'(A_TXH);
  assign avail  = ~rx_lat | rx_clr;
  assign tx_irq = tx_lat && cfg_tx_irq_en;

  always_comb begin
    grant = '0;
    gidx  = '0;
    found = 1'b0;
    for (int i = 0; i < N_RX; i++) begin
      if (avail[i] && !found) begin
        grant[i] = 1'b1;
        gidx     = SW'(i);
        found    = 1'b1;
      end
    end
  end

  generate
    for (genvar g = 0; g < N_RX; g++) begin : g_slot
      assign rx_clr[g] = rd_en && rd_addr == AW'(A_RX0 + 2*g + 1);
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          rx_lat[g] <= 1'b0;
          rx_cap[g] <= '0;
        end else begin
          rx_lat[g] <= (rx_lat[g] && !rx_clr[g]) || (grant[g] && rx_hit);
          if (grant[g] && rx_hit) rx_cap[g] <= time_ns;
        end
      end
      a_r11_slot_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_lat[g] && !rx_clr[g]) |=> $stable(rx_cap[g]));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_lat <= 1'b0;
      tx_cap <= '0;
    end else begin
      tx_lat <= (tx_lat && !tx_clr) || tx_evt;
      if (tx_evt && (!tx_lat || tx_clr)) tx_cap <= time_ns;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (rd_addr == '0)                rd_mux = DW'({tx_lat, rx_lat});
    else if (rd_addr == AW'(A_TXL))   rd_mux = tx_cap[DW-1:0];
    else if (rd_addr == AW'(A_TXH))   rd_mux = DW'(tx_cap >> DW);
    for (int i = 0; i < N_RX; i++) begin
      if (rd_addr == AW'(A_RX0 + 2*i))     rd_mux = rx_cap[i][DW-1:0];
      if (rd_addr == AW'(A_RX0 + 2*i + 1)) rd_mux = DW'(rx_cap[i] >> DW);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data    <= '0;
      rx_stamped <= 1'b0;
      rx_nostamp <= 1'b0;
      rx_slot    <= '0;
    end else begin
      if (rd_en) rd_data <= rd_mux;
      rx_stamped <= rx_hit && found;
      rx_nostamp <= rx_hit && !found;
      if (rx_hit && found) rx_slot <= gidx;
    end
  end

  a_r2_slot_latched: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stamped |-> rx_lat[rx_slot]);
  a_r6_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_hit && (&rx_lat) && !(|rx_clr)) |=> (rx_nostamp && !rx_stamped));
  a_r8_tx_keep_first: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_lat && !tx_clr) |=> $stable(tx_cap));
  a_r5_tx_release: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_clr && !tx_evt) |=> !tx_lat);
  a_r9_irq_on_capture: assert property (@(posedge clk) disable iff (!rst_n)
    tx_evt |=> (tx_irq || !cfg_tx_irq_en));
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_stamped && rx_nostamp));
endmodule

// File: tb/tb_ptp_ts_capture.sv
module tb_ptp_ts_capture;
  logic        clk = 0, rst_n = 0;
  logic [63:0] time_ns = 64'h0000_0001_FFFF_FFF0;
  logic        tx_evt = 0, rx_evt = 0, rx_udp = 0;
  logic [1:0]  rx_ver = 0, cfg_rx_mode = 0;
  logic        cfg_udp_en = 0, cfg_tx_irq_en = 0, rd_en = 0;
  logic [3:0]  rd_addr = 0;
  logic [31:0] rd_data;
  logic        rx_stamped, rx_nostamp, tx_irq;
  logic [1:0]  rx_slot;
  int checks = 0, fails = 0;

  ptp_ts_capture dut (.clk(clk), .rst_n(rst_n), .time_ns(time_ns), .tx_evt(tx_evt),
    .rx_evt(rx_evt), .rx_ver(rx_ver), .rx_udp(rx_udp), .cfg_rx_mode(cfg_rx_mode),
    .cfg_udp_en(cfg_udp_en), .cfg_tx_irq_en(cfg_tx_irq_en), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .rx_stamped(rx_stamped),
    .rx_nostamp(rx_nostamp), .rx_slot(rx_slot), .tx_irq(tx_irq));

  always #5 clk = ~clk;
  always @(posedge clk) time_ns <= time_ns + 64'd7;

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic rx_pulse(input logic [1:0] ver, input logic udp, output logic [63:0] t);
    @(negedge clk);
    rx_evt = 1; rx_ver = ver; rx_udp = udp; t = time_ns;
    @(negedge clk);
    rx_evt = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1; rd_addr = 4'(a);
    @(negedge clk);
    rd_en = 0; d = rd_data;
  endtask

  // {mode, udp_en, ver, is_udp, expect_hit}
  localparam logic [6:0] VEC [10] = '{
    {2'd0, 1'b1, 2'd1, 1'b0, 1'b0}, {2'd1, 1'b0, 2'd1, 1'b0, 1'b1},
    {2'd1, 1'b0, 2'd2, 1'b0, 1'b0}, {2'd2, 1'b0, 2'd2, 1'b0, 1'b1},
    {2'd2, 1'b0, 2'd2, 1'b1, 1'b0}, {2'd2, 1'b1, 2'd2, 1'b1, 1'b1},
    {2'd1, 1'b1, 2'd1, 1'b1, 1'b1}, {2'd3, 1'b1, 2'd3, 1'b0, 1'b0},
    {2'd1, 1'b0, 2'd1, 1'b1, 1'b0}, {2'd2, 1'b1, 2'd1, 1'b0, 1'b0}};

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] t, tf [4], tn, tx0;
    logic [31:0] d, d2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(0, d);
    chk(d, 0, "R1 status after reset");
    chk({tx_irq, rx_stamped, rx_nostamp}, 0, "R1 outputs after reset");

    foreach (VEC[k]) begin
      cfg_rx_mode = VEC[k][6:5]; cfg_udp_en = VEC[k][4];
      rx_pulse(VEC[k][3:2], VEC[k][1], t);
      chk(rx_stamped | rx_nostamp, VEC[k][0], "R7 filter vector");
      if (rx_stamped) begin
        rd(3, d);
        chk(d, t[31:0], "R7 accepted frame captured");
        rd(4, d);
      end
      rd(0, d);
      chk(d, 0, "R7 no slot held after vector");
    end

    cfg_rx_mode = 2; cfg_udp_en = 0;
    for (int s = 0; s < 4; s++) begin
      rx_pulse(2'd2, 1'b0, tf[s]);
      chk({rx_stamped, rx_slot}, {1'b1, 2'(s)}, "R2 lowest free slot");
    end
    rd(0, d);
    chk(d, 32'h0F, "R3 status all held");
    rx_pulse(2'd2, 1'b0, t);
    chk({rx_nostamp, rx_stamped}, 2'b10, "R6 full drops event");
    rd(7, d);  chk(d, tf[2][31:0], "R11 slot2 low kept");
    rd(8, d);  chk(d, tf[2][63:32], "R4 slot2 high word");
    rd(0, d);  chk(d, 32'h0B, "R5 high read frees slot2");
    rd(5, d);  chk(d, tf[1][31:0], "R4 slot1 low word");
    rd(0, d);  rd(0, d2);
    chk(d, 32'h0B, "R5 low read frees nothing");
    chk(d2, d, "R3 status read side-effect free");
    rd(6, d);
    rd(0, d);  chk(d, 32'h09, "R5 slot1 released");
    rx_pulse(2'd2, 1'b0, tn);
    chk({rx_stamped, rx_slot}, {1'b1, 2'd1}, "R2 reuse lowest free slot");
    rd(5, d);  chk(d, tn[31:0], "R2 new capture value");
    rd(6, d);  rd(8, d);

    @(negedge clk);
    rd_en = 1; rd_addr = 4; rx_evt = 1; rx_ver = 2; rx_udp = 0; t = time_ns;
    @(negedge clk);
    rd_en = 0; rx_evt = 0;
    chk({rx_stamped, rx_slot}, {1'b1, 2'd0}, "R10 clear then capture slot0");
    chk(rd_data, tf[0][63:32], "R10 read returns old value");
    rd(0, d);  chk(d, 32'h09, "R10 slot0 held again");
    rd(3, d);  chk(d, t[31:0], "R10 new value in slot0");

    cfg_tx_irq_en = 0;
    @(negedge clk); tx_evt = 1; tx0 = time_ns;
    @(negedge clk); tx_evt = 0;
    chk(tx_irq, 0, "R9 masked irq");
    rd(0, d);  chk(d[4], 1, "R3 tx status bit");
    cfg_tx_irq_en = 1;
    #1 chk(tx_irq, 1, "R9 unmasked irq");
    @(negedge clk); tx_evt = 1;
    @(negedge clk); tx_evt = 0;
    rd(1, d);  chk(d, tx0[31:0], "R8 first tx capture kept");
    rd(2, d);  chk(d, tx0[63:32], "R4 tx high word");
    rd(0, d);  chk(d[4], 0, "R5 tx latch released");
    chk(tx_irq, 0, "R9 irq drops on release");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule